// File: doc/BRIEF.md
# Pulse-Swallowing Clock Rate Divider

This block lowers the average rate of an input clock by removing whole input pulses instead of dividing by an integer. An 8-bit rate select value `N` sets how many of every 255 input pulses are kept. A modulo-255 accumulator adds `N` on each input cycle and raises the clock enable on each cycle where the sum wraps. This spreads the kept pulses as evenly as the ratio allows. Output edges are therefore generally not equally spaced.

Software writes a 32-bit control word. Only the low byte is stored; the upper bits always read back as zero. The enable is registered and then captured by a latch while the input clock is low. The gated clock output therefore only ever carries complete input high phases. A new select value acts from the next input edge without clearing the accumulator, so a rate change does not cause a burst of pulses.

Top module: `pdm_clk_div`

## Requirements
- R1: While reset is held, the stored select is 0xFF, the read port returns 0x000000FF, and `clk_en_o` and `clk_o` are low.
- R2: Bits 31:8 of `rd_data_o` always read as zero, whatever was written to them. Bits 7:0 return the stored select.
- R3: A write with `wr_en_i` high at a rising edge stores `wr_data_i[7:0]`, and `rd_data_o` shows it after that edge. Without a write, the stored value does not change.
- R4: With a constant select `N`, any 255 consecutive input cycles contain exactly `N` cycles with `clk_en_o` high, and exactly `N` high phases on `clk_o`.
- R5: With select 255, `clk_en_o` stays high on every cycle, so no pulse is removed.
- R6: With select 0, `clk_en_o` stays low, and `clk_o` carries no pulse.
- R7: With a constant nonzero `N`, the distance between consecutive enabled cycles never exceeds ceil(255/N) input cycles.
- R8: `clk_o` is high only during a high phase of `clk_i`. It is high in the cycle that follows a cycle where `clk_en_o` was high, and in no other cycle.
- R9: A select change does not reset the accumulator, and the accumulator value stays below 255. The 255 cycles that start with the first enable decision under the new value contain exactly the new `N` enabled cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock whose pulses are kept or removed |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Control word; bits 7:0 are the rate select |
| rd_data_o | output | 32 | Control word read back; upper bits are zero |
| clk_en_o | output | 1 | Registered enable, high for each kept cycle |
| clk_o | output | 1 | Gated clock, with full high phases only |

## Verification
The bench builds the block with its default parameters: an 8-bit select and a 32-bit control word, which gives a 255-cycle density period. At that size, every select value, including the extremes 0, 1, 128 and 255, can be checked exactly over a full period within a short run. Randomly drawn select values with random reserved bits are mixed with these directed values. The bench switches between them without resets, so the rate-change behaviour is exercised from many accumulator phases.

// File: rtl/pdm_div_pkg.sv
package pdm_div_pkg;
  parameter int unsigned SEL_W_DEF = 8;
  parameter int unsigned REG_W_DEF = 32;

  typedef struct packed {
    logic       wrap;
    logic [8:0] rem;
  } acc_step_t;

  // one accumulator step modulo the period, 8-bit select
  function automatic acc_step_t acc_step(input logic [7:0] acc, input logic [7:0] sel);
    logic [8:0] sum;
    acc_step_t  r;
    sum    = {1'b0, acc} + {1'b0, sel};
    r.wrap = (sum >= 9'd255);
    r.rem  = r.wrap ? (sum - 9'd255) : sum;
    return r;
  endfunction
endpackage

// File: rtl/pdm_rate_reg.sv
module pdm_rate_reg #(
  parameter int unsigned REG_W   = 32,
  parameter int unsigned SEL_W   = 8,
  parameter logic [SEL_W-1:0] RST_SEL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [SEL_W-1:0] sel_o,
  output logic [REG_W-1:0] rd_data_o
);
  localparam int unsigned RSV_W = REG_W - SEL_W;

  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sel_q <= RST_SEL;
    else if (wr_en_i) sel_q <= wr_data_i[SEL_W-1:0];
  end

  assign sel_o     = sel_q;
  assign rd_data_o = {{RSV_W{1'b0}}, sel_q};
endmodule

// File: rtl/pdm_accum.sv
module pdm_accum #(
  parameter int unsigned SEL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             en_o,
  output logic [SEL_W-1:0] acc_o
);
  localparam int unsigned SUM_W  = SEL_W + 1;
  localparam int unsigned PERIOD = (1 << SEL_W) - 1;
  localparam logic [SUM_W-1:0] PERIOD_W = SUM_W'(PERIOD);

  logic [SEL_W-1:0] acc_q;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] rem;
  logic             wrap;
  logic             en_q;

  always_comb begin
    sum  = {1'b0, acc_q} + {1'b0, sel_i};
    wrap = (sum >= PERIOD_W);
    rem  = wrap ? (sum - PERIOD_W) : sum;
  end

  // accumulator kept across select changes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      en_q  <= 1'b0;
    end else begin
      acc_q <= rem[SEL_W-1:0];
      en_q  <= wrap;
    end
  end

  assign en_o  = en_q;
  assign acc_o = acc_q;
endmodule

// File: rtl/pdm_clk_gate.sv
module pdm_clk_gate (
  input  logic clk_i,
  input  logic en_i,
  output logic clk_o
);
  logic en_lat;

  // transparent while clock low: enable cannot change during a high phase
  always_latch begin
    if (!clk_i) en_lat = en_i;
  end

  assign clk_o = clk_i & en_lat;
endmodule

// File: rtl/pdm_clk_div.sv
module pdm_clk_div #(
  parameter int unsigned REG_W = pdm_div_pkg::REG_W_DEF,
  parameter int unsigned SEL_W = pdm_div_pkg::SEL_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             clk_en_o,
  output logic             clk_o
);
  localparam logic [SEL_W-1:0] PASS_SEL = '1;

  logic [SEL_W-1:0] sel;
  logic [SEL_W-1:0] acc;
  logic             en;

  pdm_rate_reg #(
    .REG_W  (REG_W),
    .SEL_W  (SEL_W),
    .RST_SEL(PASS_SEL)
  ) u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .sel_o    (sel),
    .rd_data_o(rd_data_o)
  );

  pdm_accum #(
    .SEL_W(SEL_W)
  ) u_acc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_i (sel),
    .en_o  (en),
    .acc_o (acc)
  );

  pdm_clk_gate u_gate (
    .clk_i(clk_i),
    .en_i (en),
    .clk_o(clk_o)
  );

  assign clk_en_o = en;
endmodule

// File: rtl/pdm_clk_div_chk.sv
module pdm_clk_div_chk #(
  parameter int unsigned REG_W = 32,
  parameter int unsigned SEL_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [REG_W-1:0] wr_data_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic             clk_en_o,
  input logic [SEL_W-1:0] acc
);
  localparam int unsigned PERIOD = (1 << SEL_W) - 1;
  localparam logic [SEL_W-1:0] ALL_ONES = '1;

  // R2
  rsv_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[REG_W-1:SEL_W] == '0);

  // R3
  wr_apply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o[SEL_W-1:0] == $past(wr_data_i[SEL_W-1:0]));

  // R5
  pass_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[SEL_W-1:0] == ALL_ONES) |=> clk_en_o);

  // R6
  stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[SEL_W-1:0] == '0) |=> !clk_en_o);

  // R9
  acc_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(acc) < PERIOD);
endmodule

bind pdm_clk_div pdm_clk_div_chk #(
  .REG_W(REG_W),
  .SEL_W(SEL_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .wr_data_i(wr_data_i),
  .rd_data_o(rd_data_o),
  .clk_en_o (clk_en_o),
  .acc      (acc)
);

// File: tb/pdm_clk_div_tb.sv
module pdm_clk_div_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic        clk_en_o;
  logic        clk_o;

  int n_chk = 0;
  int n_bad = 0;

  pdm_clk_div u_dut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o),
    .clk_en_o (clk_en_o),
    .clk_o    (clk_o)
  );

  always #5 clk_i = ~clk_i;

  function automatic int max_gap(input int n);
    return (255 + n - 1) / n;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [31:0] w);
    return {24'b0, w[7:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] w);
    @(negedge clk_i);
    wr_en_i   = 1'b1;
    wr_data_i = w;
    @(negedge clk_i);
    wr_en_i   = 1'b0;
    chk(rd_data_o == exp_rd(w), "R2/R3 readback", int'(rd_data_o), int'(exp_rd(w)));
  endtask

  // 256 steps: enable counted on steps 0..254, gated clock on steps 1..255
  task automatic window(input int n, input string tag);
    int  en_cnt = 0;
    int  ck_cnt = 0;
    int  gap = 0;
    int  worst = 0;
    bit  seen = 1'b0;
    bit  prev_en = 1'b0;
    bit  align_ok = 1'b1;
    bit  low_ok = 1'b1;
    for (int i = 0; i < 256; i++) begin
      @(posedge clk_i);
      #2;
      if (i >= 1) begin
        if (clk_o) ck_cnt++;
        if (clk_o != prev_en) align_ok = 1'b0;
      end
      if (i < 255) begin
        gap++;
        if (clk_en_o) begin
          en_cnt++;
          if (seen && gap > worst) worst = gap;
          seen = 1'b1;
          gap  = 0;
        end
      end
      prev_en = clk_en_o;
      @(negedge clk_i);
      #2;
      if (clk_o) low_ok = 1'b0;
    end
    chk(en_cnt == n, {tag, " R4 enable count"}, en_cnt, n);
    chk(ck_cnt == n, {tag, " R4 gated pulses"}, ck_cnt, n);
    chk(align_ok, {tag, " R8 pulse follows enable"}, int'(align_ok), 1);
    chk(low_ok, {tag, " R8 low phase quiet"}, int'(low_ok), 1);
    if (n > 0) chk(worst <= max_gap(n), {tag, " R7 spacing"}, worst, max_gap(n));
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] w;
    int          n;
    void'($urandom(32'd4242));
    #23;
    // R1 reset state
    chk(rd_data_o == 32'h0000_00FF, "R1 reset readback", int'(rd_data_o), 255);
    chk(clk_en_o == 1'b0, "R1 enable in reset", int'(clk_en_o), 0);
    @(negedge clk_i);
    chk(clk_o == 1'b0, "R1 gated clock in reset", int'(clk_o), 0);
    @(posedge clk_i);
    #2;
    chk(clk_o == 1'b0, "R1 gated high phase in reset", int'(clk_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R5 pass-through straight out of reset
    window(255, "reset default R5");

    // directed corner values, reserved bits set to check R2
    wr(32'hFFFF_FF00); window(0, "sel0 R6");
    wr(32'h0000_0001); window(1, "sel1");
    wr(32'hA5A5_A580); window(128, "sel128 R9");
    wr(32'h0000_00FF); window(255, "sel255 R5");
    wr(32'h0000_0002); window(2, "sel2");
    wr(32'h1234_56FE); window(254, "sel254");

    // R3: no write keeps the value
    repeat (7) @(negedge clk_i);
    chk(rd_data_o == 32'h0000_00FE, "R3 hold", int'(rd_data_o), 254);

    // random selects, random reserved bits, no reset between (R9)
    for (int k = 0; k < 24; k++) begin
      w = $urandom();
      n = int'(w[7:0]);
      wr(w);
      window(n, "random R9");
    end

    // back to stop then one pulse
    wr(32'h0000_0000); window(0, "stop again R6");
    wr(32'h8000_0001); window(1, "restart");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule